// File: doc/BRIEF.md
# Decimal Up/Down Digit Counter

This block holds one decimal digit as a four-bit binary coded value (0 to 9) and moves it by one step per clock on request. Two independent request inputs select stepping up or stepping down; a load strobe copies a four-bit word into the digit, and a clear returns it to zero. All state changes happen on the rising clock edge, and every output comes straight from a register.

When the digit wraps from 9 to 0 while stepping up, a carry flag is high for exactly that one cycle. When it wraps from 0 to 9 while stepping down, a borrow flag is high for that one cycle. A chain of these blocks forms a multi-digit decimal counter by feeding one digit's carry or borrow into the next digit's request input. A loaded code above 9 is tolerated for a single cycle and then brought back into the decimal range by whatever the next cycle does.

Top module: `dec_updown_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next value of `count` is 0 and `carry` and `borrow` are 0.
- R2: `clr` high at a rising edge sets `count` to 0 with both flags low, whatever `load`, `up_req` and `dn_req` are.
- R3: With `clr` low, `load` high copies `load_data` (any of the 16 codes, binary coded, bit 3 most significant) into `count` with both flags low, whatever the requests are.
- R4: With `clr` and `load` low, `up_req` high and `dn_req` low, a `count` of 0 to 8 becomes `count`+1 with both flags low.
- R5: Under the same request, a `count` of 9 becomes 0 and `carry` is 1 in that same cycle only; `carry` is 0 in every cycle that is not such a wrap.
- R6: With `clr` and `load` low, `dn_req` high and `up_req` low, a `count` of 1 to 9 becomes `count`-1 with both flags low.
- R7: Under the same request, a `count` of 0 becomes 9 and `borrow` is 1 in that same cycle only; `borrow` is 0 in every cycle that is not such a wrap.
- R8: With `clr` and `load` low and the two requests equal (both high or both low), a `count` of 0 to 9 is held with both flags low.
- R9: A `count` of 10 to 15 (only reachable by load) moves, when `clr` and `load` are low, to 0 with `carry` 1 on an up request, to 9 with `borrow` 0 on a down request, and to 0 with both flags low when the two requests are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear to 0, highest priority |
| load | input | 1 | Parallel load strobe |
| load_data | input | 4 | Word copied into the digit on load |
| up_req | input | 1 | Step-up request |
| dn_req | input | 1 | Step-down request |
| count | output | 4 | Registered digit value, binary coded decimal |
| carry | output | 1 | One-cycle pulse on a 9-to-0 wrap |
| borrow | output | 1 | One-cycle pulse on a 0-to-9 wrap |

## Verification
Long runs of single up requests and of single down requests walk the digit across its wrap points, separating ordinary steps from wraps and showing that each flag is a pulse and not a level. Cycles with both requests high, or with load or clear raised on top of requests, separate the priority order from simple holding. Loads of codes 10 to 15 followed by each request kind show the recovery path for illegal codes, including the down case that must land on 9 without a borrow. Random mixes of all controls over thousands of cycles then compare every cycle against an independent model.

// File: rtl/dec_cnt_pkg.sv
package dec_cnt_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MOD = 10;
    localparam logic [DIGIT_W-1:0] LAST_CODE = DIGIT_W'(DIGIT_MOD - 1);
    localparam logic [DIGIT_W-1:0] ZERO_CODE = '0;

    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_LOAD  = 3'd1,
        OP_UP    = 3'd2,
        OP_DOWN  = 3'd3,
        OP_IDLE  = 3'd4
    } cnt_op_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] value;
        logic               carry;
        logic               borrow;
    } cnt_state_t;

    localparam cnt_state_t STATE_RESET = '{value: ZERO_CODE, carry: 1'b0, borrow: 1'b0};

    function automatic logic is_legal(input logic [DIGIT_W-1:0] v);
        return v <= LAST_CODE;
    endfunction

    function automatic cnt_state_t step_up(input logic [DIGIT_W-1:0] v);
        cnt_state_t s;
        s = STATE_RESET;
        if (v >= LAST_CODE) begin
            s.value = ZERO_CODE;
            s.carry = 1'b1;
        end else begin
            s.value = v + 1'b1;
        end
        return s;
    endfunction

    function automatic cnt_state_t step_down(input logic [DIGIT_W-1:0] v);
        cnt_state_t s;
        s = STATE_RESET;
        if (v == ZERO_CODE) begin
            s.value  = LAST_CODE;
            s.borrow = 1'b1;
        end else if (!is_legal(v)) begin
            s.value = LAST_CODE;
        end else begin
            s.value = v - 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/dec_cnt_decode.sv
module dec_cnt_decode
    import dec_cnt_pkg::*;
(
    input  logic    clr,
    input  logic    load,
    input  logic    up_req,
    input  logic    dn_req,
    output cnt_op_e op
);

    always_comb begin
        if (clr)
            op = OP_CLEAR;
        else if (load)
            op = OP_LOAD;
        else if (up_req && !dn_req)
            op = OP_UP;
        else if (dn_req && !up_req)
            op = OP_DOWN;
        else
            op = OP_IDLE;
    end

endmodule

// File: rtl/dec_cnt_next.sv
module dec_cnt_next
    import dec_cnt_pkg::*;
(
    input  cnt_op_e            op,
    input  logic [DIGIT_W-1:0] cur,
    input  logic [DIGIT_W-1:0] load_data,
    output cnt_state_t         nxt
);

    always_comb begin
        nxt = STATE_RESET;
        unique case (op)
            OP_CLEAR: nxt = STATE_RESET;
            OP_LOAD:  nxt.value = load_data;
            OP_UP:    nxt = step_up(cur);
            OP_DOWN:  nxt = step_down(cur);
            OP_IDLE:  nxt.value = is_legal(cur) ? cur : ZERO_CODE;
            default:  nxt = STATE_RESET;
        endcase
    end

endmodule

// File: rtl/dec_cnt_reg.sv
module dec_cnt_reg
    import dec_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_state_t nxt,
    output cnt_state_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= STATE_RESET;
        else
            q <= nxt;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (q == STATE_RESET)); // R1

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(q.carry && q.borrow)); // R5

endmodule

// File: rtl/dec_updown_counter.sv
module dec_updown_counter
    import dec_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               load,
    input  logic [DIGIT_W-1:0] load_data,
    input  logic               up_req,
    input  logic               dn_req,
    output logic [DIGIT_W-1:0] count,
    output logic               carry,
    output logic               borrow
);

    cnt_op_e    op;
    cnt_state_t nxt;
    cnt_state_t state_q;

    dec_cnt_decode u_decode (
        .clr    (clr),
        .load   (load),
        .up_req (up_req),
        .dn_req (dn_req),
        .op     (op)
    );

    dec_cnt_next u_next (
        .op        (op),
        .cur       (state_q.value),
        .load_data (load_data),
        .nxt       (nxt)
    );

    dec_cnt_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .q   (state_q)
    );

    assign count  = state_q.value;
    assign carry  = state_q.carry;
    assign borrow = state_q.borrow;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == ZERO_CODE && !carry && !borrow)); // R2

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (count == $past(load_data) && !carry && !borrow)); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && up_req && !dn_req && count < LAST_CODE)
        |=> (count == $past(count) + 1'b1 && !carry)); // R4

    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
        carry |-> (count == ZERO_CODE)); // R5

    AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (rst)
        carry |=> !carry); // R5

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && dn_req && !up_req && count != ZERO_CODE && count <= LAST_CODE)
        |=> (count == $past(count) - 1'b1 && !borrow)); // R6

    AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        borrow |-> (count == LAST_CODE)); // R7

    AST_BORROW_PULSE: assert property (@(posedge clk) disable iff (rst)
        borrow |=> !borrow); // R7

    AST_HOLD_EQUAL_REQ: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && (up_req == dn_req) && count <= LAST_CODE)
        |=> ($stable(count) && !carry && !borrow)); // R8

    AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (count > LAST_CODE && !load) |=> (count <= LAST_CODE)); // R9

endmodule

// File: tb/dec_updown_counter_tb.sv
module dec_updown_counter_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       clr;
    logic       load;
    logic [3:0] load_data;
    logic       up_req;
    logic       dn_req;
    logic [3:0] count;
    logic       carry;
    logic       borrow;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [3:0] m_cnt;
    logic       m_c;
    logic       m_b;

    always #2 clk = ~clk;

    dec_updown_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .load      (load),
        .load_data (load_data),
        .up_req    (up_req),
        .dn_req    (dn_req),
        .count     (count),
        .carry     (carry),
        .borrow    (borrow)
    );

    // Independent reference: returns {value, carry, borrow}
    function automatic logic [5:0] model(input logic [3:0] cur, input logic r,
                                         input logic cl, input logic ld,
                                         input logic [3:0] d, input logic u,
                                         input logic dn);
        if (r || cl)            return {4'd0, 2'b00};
        if (ld)                 return {d, 2'b00};
        if (u && !dn) begin
            if (cur >= 4'd9)    return {4'd0, 2'b10};
            return {cur + 4'd1, 2'b00};
        end
        if (dn && !u) begin
            if (cur == 4'd0)    return {4'd9, 2'b01};
            if (cur > 4'd9)     return {4'd9, 2'b00};
            return {cur - 4'd1, 2'b00};
        end
        if (cur > 4'd9)         return {4'd0, 2'b00};
        return {cur, 2'b00};
    endfunction

    function automatic string req_tag(input logic [3:0] cur, input logic r,
                                      input logic cl, input logic ld,
                                      input logic u, input logic dn);
        if (r)                  return "R1";
        if (cl)                 return "R2";
        if (ld)                 return "R3";
        if (cur > 4'd9)         return "R9";
        if (u && !dn)           return (cur == 4'd9) ? "R5" : "R4";
        if (dn && !u)           return (cur == 4'd0) ? "R7" : "R6";
        return "R8";
    endfunction

    task automatic cycle(input logic r, input logic cl, input logic ld,
                         input logic [3:0] d, input logic u, input logic dn);
        logic [5:0] exp;
        string      tag;
        rst = r; clr = cl; load = ld; load_data = d; up_req = u; dn_req = dn;
        exp = model(m_cnt, r, cl, ld, d, u, dn);
        tag = req_tag(m_cnt, r, cl, ld, u, dn);
        @(posedge clk);
        #1;
        {m_cnt, m_c, m_b} = exp;
        checks++;
        if (count !== m_cnt || carry !== m_c || borrow !== m_b) begin
            failures++;
            $display("FAIL %s: count=%0d carry=%0b borrow=%0b expected count=%0d carry=%0b borrow=%0b",
                     tag, count, carry, borrow, m_cnt, m_c, m_b);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int unsigned rv;
        seed = 32'd1337;
        void'($urandom(seed));
        m_cnt = 4'd0; m_c = 1'b0; m_b = 1'b0;
        rst = 1'b1; clr = 1'b0; load = 1'b0; load_data = 4'd0; up_req = 1'b0; dn_req = 1'b0;
        #1;
        // R1: reset state
        cycle(1, 0, 0, 4'd0, 0, 0);
        cycle(1, 0, 0, 4'd0, 1, 0);
        // R4 / R5: up walk through two wraps
        for (int i = 0; i < 22; i++) cycle(0, 0, 0, 4'd0, 1, 0);
        // R6 / R7: down walk through two wraps
        for (int i = 0; i < 22; i++) cycle(0, 0, 0, 4'd0, 0, 1);
        // R8: both requests and no request hold
        cycle(0, 0, 1, 4'd5, 0, 0);
        cycle(0, 0, 0, 4'd0, 1, 1);
        cycle(0, 0, 0, 4'd0, 0, 0);
        // R2: clear beats load and requests
        cycle(0, 1, 1, 4'd7, 1, 0);
        cycle(0, 0, 1, 4'd9, 0, 0);
        cycle(0, 1, 0, 4'd0, 0, 1);
        // R3: load beats requests, including illegal codes
        cycle(0, 0, 1, 4'd3, 1, 0);
        cycle(0, 0, 1, 4'd15, 0, 1);
        // R9: illegal recovery for each request kind
        for (int code = 10; code < 16; code++) begin
            cycle(0, 0, 1, 4'(code), 0, 0);
            cycle(0, 0, 0, 4'd0, 1, 0);
            cycle(0, 0, 1, 4'(code), 0, 0);
            cycle(0, 0, 0, 4'd0, 0, 1);
            cycle(0, 0, 1, 4'(code), 0, 0);
            cycle(0, 0, 0, 4'd0, 1, 1);
            cycle(0, 0, 1, 4'(code), 0, 0);
            cycle(0, 0, 0, 4'd0, 0, 0);
        end
        // Random mix, counting requests weighted heavily
        for (int i = 0; i < 4000; i++) begin
            rv = $urandom;
            cycle((rv[7:0] == 8'd0),
                  (rv[11:8] == 4'd0),
                  (rv[15:12] == 4'd0),
                  rv[19:16],
                  (rv[22:20] < 3'd5),
                  (rv[26:24] < 3'd3));
        end
        rst = 1'b0; clr = 1'b0; load = 1'b0; up_req = 1'b0; dn_req = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule